// File: doc/BRIEF.md
# Pre-decoded Fetch Cache with Branch Folding

This block is a small direct-mapped instruction cache for the front end of a pipelined core. Each line carries an instruction that has already been decoded, a two-bit successor kind and the full address from which fetch continues. Fetch never adds four to its program counter. On a hit it loads the successor address stored in the line, so the next address costs one multiplexer in front of the PC register and nothing more.

The fill side supplies each line with its successor already worked out. An ordinary instruction gets its own address plus four. When the instruction after a line is an unconditional jump, the jump is dropped and its target becomes that line's successor, so the jump costs no fetch cycle. When that dropped jump also saves a return address, the line is marked as a folded link: one cycle after it is fetched, the block drives a link-register write of the removed jump's address plus four. That write takes the register-file write port in that cycle. A conditional branch is stored with its target as the successor, which means it is predicted taken. A resolve port reports the real outcome. A not-taken branch resolved as mispredicted raises a one-cycle squash and restarts fetch at the branch's fall-through address.

Top module: `fold_fetch_cache`

## Requirements
- R1: After reset the fetch PC is 0 and no line is valid, so the block shows `miss_req`=1, `miss_addr`=0, `fetch_valid`=0, `squash`=0 and `link_valid`=0.
- R2: A lookup hits when the line at index PC[5:2] is valid and its stored tag equals PC[31:6]. On a hit, `fetch_valid`=1 and `miss_req`=0, and `fetch_insn` and `fetch_kind` show the stored line. Kind encoding: 0 = sequential, 1 = conditional branch, 2 = folded link, 3 = handled like 0.
- R3: On a miss, `miss_req`=1 and `miss_addr`=PC, and the PC holds. A fill written at the PC's address in that cycle makes the next cycle a hit that shows the filled instruction.
- R4: On a hit with no redirect, the next-cycle PC is the stored successor address. A folded jump therefore needs no cycle of its own.
- R5: A kind-1 line fetched with no redirect moves fetch straight to its stored branch target in the next cycle.
- R6: When a kind-2 line is fetched and no redirect occurs in that cycle, the next cycle has `link_valid`=1 with `link_data` = that line's address + 8. `link_valid` is 0 in every other cycle.
- R7: A resolve with `res_valid`=1, `res_mispredict`=1 and `res_taken`=0 takes priority over fetch sequencing. The next cycle has PC = `res_addr`+4 and `squash`=1, and `squash` returns to 0 after one cycle unless another such resolve arrives.
- R8: A resolve with `res_taken`=1, or with `res_mispredict`=0, has no effect: no squash, and the PC follows R3 and R4.
- R9: A fill to an index that holds a different tag replaces that line. The old address then misses and the new address hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fill_valid | input | 1 | Write one line this cycle |
| fill_addr | input | ADDR_W | Address of the line being written |
| fill_insn | input | INSN_W | Decoded instruction for the line |
| fill_kind | input | 2 | Successor kind (see R2) |
| fill_next | input | ADDR_W | Precomputed successor fetch address |
| res_valid | input | 1 | A branch outcome is reported |
| res_addr | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Branch was actually taken |
| res_mispredict | input | 1 | Prediction was wrong |
| fetch_valid | output | 1 | Current PC hits; instruction presented |
| fetch_pc | output | ADDR_W | Current fetch address |
| fetch_insn | output | INSN_W | Instruction at the fetch address |
| fetch_kind | output | 2 | Successor kind of the fetched line |
| miss_req | output | 1 | Current PC misses; a fill is requested |
| miss_addr | output | ADDR_W | Address to be filled |
| squash | output | 1 | One-cycle kill of the wrong-path instruction |
| link_valid | output | 1 | Link-register write strobe for a folded call |
| link_data | output | ADDR_W | Return address to write |

## Verification
The bench uses the default parameters: 32-bit addresses and instructions and 16 lines. The random stimulus keeps fill and redirect addresses inside the low 256 bytes, so every index is shared by four tags. This makes evictions, refills over a live line, and fills that land in the same cycle as a hit on the same index common events. Successor fields are also random within that window, so sequential, branch and folded-link lines chain into loops that revisit replaced entries while mispredict resolves arrive at arbitrary points.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  typedef enum logic [1:0] {
    NK_SEQ    = 2'd0,
    NK_BRANCH = 2'd1,
    NK_LINK   = 2'd2,
    NK_RSVD   = 2'd3
  } next_kind_e;
endpackage

// File: rtl/ffc_rst_sync.sv
module ffc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ffc_store.sv
module ffc_store #(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [INSN_W-1:0] wr_insn,
  input  logic [1:0]        wr_kind,
  input  logic [ADDR_W-1:0] wr_next,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [INSN_W-1:0] rd_insn,
  output logic [1:0]        rd_kind,
  output logic [ADDR_W-1:0] rd_next
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [1:0]        kind;
    logic [ADDR_W-1:0] nxt;
    logic [INSN_W-1:0] insn;
  } line_t;

  line_t            line_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] valid_d;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [TAG_W-1:0] rd_tag;
  line_t            wr_line;
  line_t            rd_line;
  logic             unused_lsb;

  assign wr_idx = wr_addr[IDX_W+1:2];
  assign rd_idx = rd_addr[IDX_W+1:2];
  assign rd_tag = rd_addr[ADDR_W-1:IDX_W+2];
  assign unused_lsb = ^{wr_addr[1:0], rd_addr[1:0]};

  assign wr_line.tag  = wr_addr[ADDR_W-1:IDX_W+2];
  assign wr_line.kind = wr_kind;
  assign wr_line.nxt  = wr_next;
  assign wr_line.insn = wr_insn;

  // per-line valid next state
  for (genvar e = 0; e < DEPTH; e++) begin : g_valid
    assign valid_d[e] = valid_q[e] | (wr_en && (wr_idx == IDX_W'(e)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= '0;
    else if (wr_en) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) line_q[wr_idx] <= wr_line;
  end

  assign rd_line = line_q[rd_idx];

  always_comb begin
    rd_hit  = valid_q[rd_idx] && (rd_line.tag == rd_tag);
    rd_insn = '0;
    rd_kind = 2'd0;
    rd_next = '0;
    if (rd_hit) begin
      rd_insn = rd_line.insn;
      rd_kind = rd_line.kind;
      rd_next = rd_line.nxt;
    end
  end
endmodule

// File: rtl/ffc_pc.sv
module ffc_pc #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_next,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] restart,
  output logic [ADDR_W-1:0] pc
);
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic              pc_en;

  always_comb begin
    pc_en = redirect | hit;
    pc_d  = pc_q;
    if (redirect)  pc_d = restart;
    else if (hit)  pc_d = hit_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc = pc_q;
endmodule

// File: rtl/ffc_side.sv
module ffc_side #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect,
  input  logic              link_fire,
  input  logic [ADDR_W-1:0] link_value,
  output logic              squash,
  output logic              link_valid,
  output logic [ADDR_W-1:0] link_data
);
  logic              squash_q, squash_d;
  logic              lv_q, lv_d;
  logic [ADDR_W-1:0] ld_q;

  always_comb begin
    squash_d = redirect;
    lv_d     = link_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      squash_q <= 1'b0;
      lv_q     <= 1'b0;
    end else begin
      squash_q <= squash_d;
      lv_q     <= lv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ld_q <= '0;
    else if (link_fire) ld_q <= link_value;
  end

  assign squash     = squash_q;
  assign link_valid = lv_q;
  assign link_data  = ld_q;
endmodule

// File: rtl/fold_fetch_cache.sv
module fold_fetch_cache #(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [INSN_W-1:0] fill_insn,
  input  logic [1:0]        fill_kind,
  input  logic [ADDR_W-1:0] fill_next,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic              res_taken,
  input  logic              res_mispredict,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [INSN_W-1:0] fetch_insn,
  output logic [1:0]        fetch_kind,
  output logic              miss_req,
  output logic [ADDR_W-1:0] miss_addr,
  output logic              squash,
  output logic              link_valid,
  output logic [ADDR_W-1:0] link_data
);
  import ffc_pkg::*;

  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] LINK_OFS = ADDR_W'(8);

  logic              core_rst_n;
  logic [ADDR_W-1:0] pc;
  logic              rd_hit;
  logic [INSN_W-1:0] rd_insn;
  logic [1:0]        rd_kind;
  logic [ADDR_W-1:0] rd_next;
  logic              redirect;
  logic [ADDR_W-1:0] restart;
  logic              link_fire;

  ffc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  ffc_store #(.ADDR_W(ADDR_W), .INSN_W(INSN_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (fill_valid),
    .wr_addr (fill_addr),
    .wr_insn (fill_insn),
    .wr_kind (fill_kind),
    .wr_next (fill_next),
    .rd_addr (pc),
    .rd_hit  (rd_hit),
    .rd_insn (rd_insn),
    .rd_kind (rd_kind),
    .rd_next (rd_next)
  );

  // only a not-taken outcome of a predicted-taken entry redirects
  assign redirect  = res_valid & res_mispredict & ~res_taken;
  assign restart   = res_addr + STEP;
  assign link_fire = rd_hit && (next_kind_e'(rd_kind) == NK_LINK) && !redirect;

  ffc_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .hit      (rd_hit),
    .hit_next (rd_next),
    .redirect (redirect),
    .restart  (restart),
    .pc       (pc)
  );

  ffc_side #(.ADDR_W(ADDR_W)) u_side (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .redirect   (redirect),
    .link_fire  (link_fire),
    .link_value (pc + LINK_OFS),
    .squash     (squash),
    .link_valid (link_valid),
    .link_data  (link_data)
  );

  assign fetch_valid = rd_hit;
  assign fetch_pc    = pc;
  assign fetch_insn  = rd_insn;
  assign fetch_kind  = rd_kind;
  assign miss_req    = ~rd_hit;
  assign miss_addr   = pc;
endmodule

// File: rtl/ffc_chk.sv
module ffc_chk #(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic [INSN_W-1:0] fill_insn,
  input logic              res_valid,
  input logic [ADDR_W-1:0] res_addr,
  input logic              res_taken,
  input logic              res_mispredict,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic [INSN_W-1:0] fetch_insn,
  input logic [1:0]        fetch_kind,
  input logic              miss_req,
  input logic              squash,
  input logic              link_valid,
  input logic [ADDR_W-1:0] link_data,
  input logic [ADDR_W-1:0] nxt
);
  logic redir;
  assign redir = res_valid && res_mispredict && !res_taken;

  // R2
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid != miss_req);

  // R3
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req && !redir |=> fetch_pc == $past(fetch_pc));

  // R3
  fill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && miss_req && (fill_addr == fetch_pc) && !redir
    |=> fetch_valid && (fetch_insn == $past(fill_insn)));

  // R4
  follow_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !redir |=> fetch_pc == $past(nxt));

  // R6
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> $past(fetch_valid && fetch_kind == 2'd2)
                   && (link_data == $past(fetch_pc) + ADDR_W'(8)));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir |=> squash && (fetch_pc == $past(res_addr) + ADDR_W'(4)));

  // R8
  squash_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> $past(redir));
endmodule

bind fold_fetch_cache ffc_chk #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_chk (
  .clk            (clk),
  .rst_n          (core_rst_n),
  .fill_valid     (fill_valid),
  .fill_addr      (fill_addr),
  .fill_insn      (fill_insn),
  .res_valid      (res_valid),
  .res_addr       (res_addr),
  .res_taken      (res_taken),
  .res_mispredict (res_mispredict),
  .fetch_valid    (fetch_valid),
  .fetch_pc       (fetch_pc),
  .fetch_insn     (fetch_insn),
  .fetch_kind     (fetch_kind),
  .miss_req       (miss_req),
  .squash         (squash),
  .link_valid     (link_valid),
  .link_data      (link_data),
  .nxt            (rd_next)
);

// File: tb/sim_fold_fetch_cache.sv
module sim_fold_fetch_cache;
  logic        clk;
  logic        rst_n;
  logic        fill_valid;
  logic [31:0] fill_addr;
  logic [31:0] fill_insn;
  logic [1:0]  fill_kind;
  logic [31:0] fill_next;
  logic        res_valid;
  logic [31:0] res_addr;
  logic        res_taken;
  logic        res_mispredict;
  logic        fetch_valid;
  logic [31:0] fetch_pc;
  logic [31:0] fetch_insn;
  logic [1:0]  fetch_kind;
  logic        miss_req;
  logic [31:0] miss_addr;
  logic        squash;
  logic        link_valid;
  logic [31:0] link_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state
  logic [31:0] m_pc;
  bit          m_val  [16];
  logic [25:0] m_tag  [16];
  logic [1:0]  m_kind [16];
  logic [31:0] m_next [16];
  logic [31:0] m_insn [16];
  bit          m_sq;
  bit          m_lv;
  logic [31:0] m_ld;

  fold_fetch_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_insn(fill_insn),
    .fill_kind(fill_kind), .fill_next(fill_next),
    .res_valid(res_valid), .res_addr(res_addr), .res_taken(res_taken),
    .res_mispredict(res_mispredict),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_insn(fetch_insn),
    .fetch_kind(fetch_kind), .miss_req(miss_req), .miss_addr(miss_addr),
    .squash(squash), .link_valid(link_valid), .link_data(link_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int idx_of(logic [31:0] a);
    return int'(a[5:2]);
  endfunction

  function automatic logic [25:0] tag_of(logic [31:0] a);
    return a[31:6];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    fill_valid = 0; fill_addr = '0; fill_insn = '0; fill_kind = '0; fill_next = '0;
    res_valid = 0; res_addr = '0; res_taken = 0; res_mispredict = 0;
  endtask

  task automatic set_fill(logic [31:0] a, logic [31:0] ins, logic [1:0] k, logic [31:0] n);
    fill_valid = 1; fill_addr = a; fill_insn = ins; fill_kind = k; fill_next = n;
  endtask

  task automatic set_res(logic [31:0] a, bit t, bit m);
    res_valid = 1; res_addr = a; res_taken = t; res_mispredict = m;
  endtask

  // one cycle: compare outputs against the reference, advance the reference
  task automatic step();
    int          i;
    bit          hit, redir, nlv;
    logic [31:0] pcn, nld;
    bit          fv;
    logic [31:0] fa, fi, fn;
    logic [1:0]  fk;
    #1;
    i   = idx_of(m_pc);
    hit = m_val[i] && (m_tag[i] == tag_of(m_pc));
    check(fetch_valid == hit, "R2 hit flag", 32'(fetch_valid), 32'(hit));
    check(fetch_pc == m_pc, "R4/R5/R7 fetch address", fetch_pc, m_pc);
    if (hit) begin
      check(fetch_insn == m_insn[i], "R2 instruction", fetch_insn, m_insn[i]);
      check(fetch_kind == m_kind[i], "R2 kind", 32'(fetch_kind), 32'(m_kind[i]));
      check(miss_req == 1'b0, "R2 no miss on hit", 32'(miss_req), 32'd0);
    end else begin
      check(miss_req == 1'b1, "R3 miss request", 32'(miss_req), 32'd1);
      check(miss_addr == m_pc, "R3 miss address", miss_addr, m_pc);
    end
    check(squash == m_sq, "R7/R8 squash", 32'(squash), 32'(m_sq));
    check(link_valid == m_lv, "R6 link strobe", 32'(link_valid), 32'(m_lv));
    if (m_lv) check(link_data == m_ld, "R6 link value", link_data, m_ld);
    redir = res_valid && res_mispredict && !res_taken;
    pcn   = redir ? res_addr + 32'd4 : (hit ? m_next[i] : m_pc);
    nlv   = hit && (m_kind[i] == 2'd2) && !redir;
    nld   = m_pc + 32'd8;
    fv = fill_valid; fa = fill_addr; fi = fill_insn; fk = fill_kind; fn = fill_next;
    @(posedge clk);
    m_pc = pcn;
    m_sq = redir;
    m_lv = nlv;
    if (nlv) m_ld = nld;
    if (fv) begin
      m_val[idx_of(fa)]  = 1;
      m_tag[idx_of(fa)]  = tag_of(fa);
      m_kind[idx_of(fa)] = fk;
      m_next[idx_of(fa)] = fn;
      m_insn[idx_of(fa)] = fi;
    end
    @(negedge clk);
    clear_inputs();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_inputs();
    rst_n = 0;
    m_pc = '0; m_sq = 0; m_lv = 0; m_ld = '0;
    for (int e = 0; e < 16; e++) begin
      m_val[e] = 0; m_tag[e] = '0; m_kind[e] = '0; m_next[e] = '0; m_insn[e] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(fetch_valid == 0 && miss_req == 1, "R1 empty after reset", 32'(fetch_valid), 32'd0);
    check(miss_addr == 32'd0, "R1 fetch starts at zero", miss_addr, 32'd0);
    check(squash == 0 && link_valid == 0, "R1 no squash or link", 32'({squash, link_valid}), 32'd0);

    // R3 stall then refill
    step();
    set_fill(32'h0, 32'hA000_0001, 2'd0, 32'h4); step();
    check(fetch_valid && fetch_insn == 32'hA000_0001, "R3 fill becomes hit", fetch_insn, 32'hA000_0001);

    // R4 sequential, then a line whose successor is a folded jump target
    set_fill(32'h4, 32'hA000_0002, 2'd0, 32'h40); step();
    set_fill(32'h40, 32'hB000_0001, 2'd1, 32'h80); step();
    check(fetch_pc == 32'h40, "R4 folded jump costs no cycle", fetch_pc, 32'h40);

    // R5 branch predicted taken
    set_fill(32'h80, 32'hA000_0003, 2'd0, 32'h84); step();
    check(fetch_pc == 32'h80 && fetch_valid, "R5 target fetched next", fetch_pc, 32'h80);

    // R7 not-taken resolve restarts at fall-through
    set_res(32'h40, 0, 1); step();
    check(squash == 1, "R7 squash pulse", 32'(squash), 32'd1);
    check(fetch_pc == 32'h44, "R7 restart address", fetch_pc, 32'h44);

    set_fill(32'h44, 32'hC000_0001, 2'd2, 32'hC0); step();
    check(squash == 0, "R7 squash lasts one cycle", 32'(squash), 32'd0);

    // R6 folded link
    step();
    check(link_valid == 1 && link_data == 32'h4C, "R6 link write", link_data, 32'h4C);
    check(fetch_pc == 32'hC0, "R6 call target fetched", fetch_pc, 32'hC0);

    // R8 ignored resolves
    set_fill(32'hC0, 32'hA000_0004, 2'd0, 32'hC4); set_res(32'h40, 1, 1); step();
    check(squash == 0 && fetch_pc == 32'hC0, "R8 taken resolve ignored", fetch_pc, 32'hC0);
    check(link_valid == 0, "R6 strobe drops", 32'(link_valid), 32'd0);
    set_res(32'h40, 0, 0); step();
    check(squash == 0 && fetch_pc == 32'hC4, "R8 correct resolve ignored", fetch_pc, 32'hC4);

    // R9 replacement at a shared index
    set_fill(32'h100, 32'hD000_0001, 2'd0, 32'h104); step();
    set_res(32'hFC, 0, 1); step();
    check(fetch_valid && fetch_insn == 32'hD000_0001, "R9 new tag hits", fetch_insn, 32'hD000_0001);
    set_res(32'hFFFF_FFFC, 0, 1); step();
    check(fetch_pc == 32'h0 && miss_req == 1, "R9 old tag evicted", 32'(miss_req), 32'd1);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      int  i;
      bit  hit;
      i   = idx_of(m_pc);
      hit = m_val[i] && (m_tag[i] == tag_of(m_pc));
      if (!hit && ($urandom % 10) < 7)
        set_fill(m_pc, $urandom, 2'($urandom % 4), 32'(($urandom % 64) * 4));
      else if (($urandom % 10) < 3)
        set_fill(32'(($urandom % 64) * 4), $urandom, 2'($urandom % 4), 32'(($urandom % 64) * 4));
      if (($urandom % 100) < 15)
        set_res(32'(($urandom % 64) * 4), 1'($urandom % 2), 1'($urandom % 2));
      step();
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule